// File: doc/BRIEF.md
# Shift-Insert Constant Builder

This execution unit sits in the integer pipeline of a 64-bit core. It builds wide immediate constants from a short chain of instructions. Each operation takes a register value, shifts it left by one chunk width and places a fresh literal chunk from the instruction word into the vacated low bits. Software can build any 64-bit value in two ways. The first is four narrow (16-bit) inserts, starting from a zero register. The second is one wide seed followed by two wide (22-bit) inserts.

A complemented narrow insert fills the low bits with the inverted literal and sets every bit above it. This gives negative constants shorter chains. The seed writes a sign-extended 22-bit literal. The unit takes one operation per cycle and returns a registered result one cycle later, together with a valid flag.

Top module: `sis_unit`

## Requirements
- R1: Opcode 3'b000 (narrow insert) yields `(src_i << 16) | lit_i[15:0]`, with the literal zero-extended.
- R2: Opcode 3'b001 (complemented narrow insert) yields `(src_i << 16) | ~zext(lit_i[15:0])`, complemented over 64 bits. Result bits 63:16 are therefore all ones whatever the source.
- R3: Opcode 3'b010 (wide insert) yields `(src_i << 22) | lit_i[21:0]`, with the literal zero-extended.
- R4: Opcode 3'b011 (seed) yields `lit_i[21:0]` sign-extended from bit 21 to 64 bits, and ignores `src_i`.
- R5: Opcodes 3'b100 through 3'b111 yield a result of zero.
- R6: Source bits shifted beyond bit 63 are dropped silently, and no flag is raised.
- R7: `out_valid_o` in a cycle equals `in_valid_i` of the previous cycle, and `result_o` carries the result of the operation accepted on that edge.
- R8: While `in_valid_i` is low, `result_o` keeps its last value.
- R9: Asserting `rst_ni` low clears `out_valid_o` and `result_o` to zero.
- R10: Four chained narrow inserts, starting with a zero source, rebuild any 64-bit constant. A seed followed by two chained wide inserts also rebuilds any 64-bit constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation select |
| src_i | input | 64 | Source register value |
| lit_i | input | 22 | Literal field from the instruction |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 64 | Registered result |

## Verification
Two operations can meet in one cycle when issue is back to back. The result of one operation is leaving the output register on the same edge that captures the next operation. The bench issues pairs of different opcodes on consecutive cycles, then lets the input drop idle. It checks each result in the cycle it is due, and it checks that the idle cycle clears the valid flag while the data holds.

// File: rtl/sis_pkg.sv
package sis_pkg;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned NARROW_W = 16;
  localparam int unsigned WIDE_W   = 22;
  localparam int unsigned OP_W     = 3;

  typedef enum logic [OP_W-1:0] {
    OP_INS_N  = 3'b000,
    OP_INS_NC = 3'b001,
    OP_INS_W  = 3'b010,
    OP_SEED_W = 3'b011
  } sis_op_e;
endpackage

// File: rtl/sis_op_decode.sv
module sis_op_decode
  import sis_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output logic            sel_narrow_o,
  output logic            compl_o,
  output logic            sel_wide_o,
  output logic            seed_o
);
  always_comb begin
    sel_narrow_o = 1'b0;
    compl_o      = 1'b0;
    sel_wide_o   = 1'b0;
    seed_o       = 1'b0;
    case (op_i)
      OP_INS_N:  sel_narrow_o = 1'b1;
      OP_INS_NC: begin sel_narrow_o = 1'b1; compl_o = 1'b1; end
      OP_INS_W:  sel_wide_o   = 1'b1;
      OP_SEED_W: begin sel_wide_o = 1'b1; seed_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/sis_chunk_ins.sv
module sis_chunk_ins #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned CHUNK_W = 16
) (
  input  logic [DATA_W-1:0]  src_i,
  input  logic [CHUNK_W-1:0] chunk_i,
  input  logic               compl_i,
  input  logic               seed_i,
  output logic [DATA_W-1:0]  res_o
);
  localparam int unsigned PAD_W = DATA_W - CHUNK_W;

  logic [DATA_W-1:0] zext, ins, shifted, sext;

  always_comb begin
    zext    = {{PAD_W{1'b0}}, chunk_i};
    sext    = {{PAD_W{chunk_i[CHUNK_W-1]}}, chunk_i};
    // upper source bits fall off the top
    shifted = src_i << CHUNK_W;
    ins     = compl_i ? ~zext : zext;
    res_o   = seed_i ? sext : (shifted | ins);
  end
endmodule

// File: rtl/sis_result_reg.sv
module sis_result_reg #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) data_o <= data_i;
    end
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> valid_o);
  // R7
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> !valid_o);
  // R8
  hold_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(data_o));
endmodule

// File: rtl/sis_unit.sv
module sis_unit
  import sis_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [2:0]        op_i,
  input  logic [63:0]       src_i,
  input  logic [21:0]       lit_i,
  output logic              out_valid_o,
  output logic [63:0]       result_o
);
  logic sel_narrow, compl, sel_wide, seed;
  logic [DATA_W-1:0] narrow_res, wide_res, next_res;

  sis_op_decode u_dec (
    .op_i        (op_i),
    .sel_narrow_o(sel_narrow),
    .compl_o     (compl),
    .sel_wide_o  (sel_wide),
    .seed_o      (seed)
  );

  sis_chunk_ins #(.DATA_W(DATA_W), .CHUNK_W(NARROW_W)) u_narrow (
    .src_i  (src_i),
    .chunk_i(lit_i[NARROW_W-1:0]),
    .compl_i(compl),
    .seed_i (1'b0),
    .res_o  (narrow_res)
  );

  sis_chunk_ins #(.DATA_W(DATA_W), .CHUNK_W(WIDE_W)) u_wide (
    .src_i  (src_i),
    .chunk_i(lit_i),
    .compl_i(1'b0),
    .seed_i (seed),
    .res_o  (wide_res)
  );

  always_comb begin
    next_res = '0;
    if (sel_narrow)    next_res = narrow_res;
    else if (sel_wide) next_res = wide_res;
  end

  sis_result_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (in_valid_i),
    .data_i (next_res),
    .valid_o(out_valid_o),
    .data_o (result_o)
  );

  // R1
  narrow_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == OP_INS_N) |=> result_o[15:0] == $past(lit_i[15:0]));
  // R2
  compl_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == OP_INS_NC) |=> &result_o[63:16]);
  // R4
  seed_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == OP_SEED_W) |=> (&result_o[63:21] || ~|result_o[63:21]));
  // R5
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i[2]) |=> result_o == '0);
  // R3
  wide_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == OP_INS_W) |=> result_o[21:0] == $past(lit_i));
endmodule

// File: tb/sis_unit_tb.sv
`timescale 1ns/1ps
module sis_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] src = '0;
  logic [21:0] lit = '0;
  logic        out_valid;
  logic [63:0] result;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sis_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .op_i(op),
    .src_i(src), .lit_i(lit), .out_valid_o(out_valid), .result_o(result)
  );

  function automatic logic [63:0] ref_calc(logic [2:0] o, logic [63:0] s, logic [21:0] l);
    case (o)
      3'd0: return (s << 16) | {48'b0, l[15:0]};
      3'd1: return (s << 16) | ~{48'b0, l[15:0]};
      3'd2: return (s << 22) | {42'b0, l};
      3'd3: return {{42{l[21]}}, l};
      default: return 64'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // issue one op, sample one cycle later at the falling edge
  task automatic run_op(logic [2:0] o, logic [63:0] s, logic [21:0] l, output logic [63:0] r);
    @(negedge clk);
    in_valid = 1'b1; op = o; src = s; lit = l;
    @(negedge clk);
    in_valid = 1'b0;
    r = result;
  endtask

  task automatic op_check(string req, logic [2:0] o, logic [63:0] s, logic [21:0] l);
    logic [63:0] r;
    run_op(o, s, l, r);
    chk({req, " valid"}, {63'b0, out_valid}, 64'd1);
    chk(req, r, ref_calc(o, s, l));
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 valid", {63'b0, out_valid}, 64'd0);
    chk("R9 data", result, 64'd0);
    rst_ni = 1'b1;
  endtask

  task automatic t_each_op();
    op_check("R1", 3'd0, 64'h0123_4567_89AB_CDEF, 22'h3F_1234);
    op_check("R1", 3'd0, 64'h0, 22'h00_FFFF);
    op_check("R2", 3'd1, 64'h0, 22'h00_0005);
    op_check("R2", 3'd1, 64'h0000_1234_0000_0000, 22'h2A_F0F0);
    op_check("R3", 3'd2, 64'h0000_0000_0ABC_DEF1, 22'h3F_FFFF);
    op_check("R4", 3'd3, 64'hDEAD_BEEF_DEAD_BEEF, 22'h20_0001);
    op_check("R4", 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 22'h1F_FFFF);
    for (int o = 4; o < 8; o++)
      op_check("R5", 3'(o), 64'hFFFF_FFFF_FFFF_FFFF, 22'h3F_FFFF);
  endtask

  task automatic t_overflow();
    logic [63:0] r;
    run_op(3'd0, 64'hFFFF_0000_0000_0001, 22'h0, r);
    chk("R6 narrow", r, 64'h0000_0000_0001_0000);
    run_op(3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 22'h0, r);
    chk("R6 wide", r, 64'hFFFF_FFFF_FFC0_0000);
  endtask

  task automatic t_back2back();
    @(negedge clk);
    in_valid = 1'b1; op = 3'd0; src = 64'h1111; lit = 22'h2222;
    @(negedge clk);
    chk("R7 first", result, ref_calc(3'd0, 64'h1111, 22'h2222));
    op = 3'd3; lit = 22'h2B_CDEF;
    @(negedge clk);
    chk("R7 second", result, ref_calc(3'd3, 64'h1111, 22'h2B_CDEF));
    chk("R7 valid", {63'b0, out_valid}, 64'd1);
    in_valid = 1'b0; op = 3'd1; src = 64'h5; lit = 22'h7;
    @(negedge clk);
    chk("R7 drop", {63'b0, out_valid}, 64'd0);
    chk("R8 hold", result, ref_calc(3'd3, 64'h1111, 22'h2B_CDEF));
  endtask

  task automatic t_chains();
    logic [63:0] c, acc;
    for (int n = 0; n < 20; n++) begin
      c = {$urandom, $urandom};
      if (n == 0) c = 64'h8000_0000_0000_0000;
      if (n == 1) c = 64'hFFFF_FFFF_FFFF_FFFF;
      acc = 64'h0;
      for (int k = 3; k >= 0; k--)
        run_op(3'd0, acc, {6'b0, c[k*16 +: 16]}, acc);
      chk("R10 narrow chain", acc, c);
      run_op(3'd3, 64'hA5A5_A5A5_A5A5_A5A5, {2'b00, c[63:44]}, acc);
      run_op(3'd2, acc, c[43:22], acc);
      run_op(3'd2, acc, c[21:0], acc);
      chk("R10 wide chain", acc, c);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    t_reset();
    t_each_op();
    t_overflow();
    t_back2back();
    t_chains();
    t_reset();
    summary();
  end

  initial begin
    #1_000_000;
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end
endmodule